// File: doc/BRIEF.md
# Register-Programmed SPI Master with Phased Transfers

This block is an SPI master that software drives through a small word-addressed register bus. Bytes to be sent are written into a transmit FIFO and received bytes are read from a receive FIFO. A transfer-control register holds a 4-bit mode code and two byte counts, one for the write phase and one for the read phase. Any write to the command register starts the programmed transfer. A sequencer then runs the phases under a single chip-select assertion.

The supported mode codes are 0 (simultaneous exchange), 1 (send only), 2 (receive only) and 3 (send, then receive). Code 7 and every other code perform no data movement. SCLK follows SPI mode 0: it idles low, MOSI changes while SCLK is low, MISO is sampled on the rising edge, and bytes go most significant bit first. Software polls a status word for the busy flag and the FIFO levels. It can empty either FIFO, or abort the engine, through control bits that clear themselves.

The register map, by byte offset:

| Offset | Register | Access |
|---|---|---|
| 0x00 | format | read-only |
| 0x04 | transfer control | read/write |
| 0x08 | command | write-only |
| 0x0C | data | read/write |
| 0x10 | control | read/write |
| 0x14 | status | read-only |
| 0x18 | timing | read/write |

Top module: `spi_xfer_master`

## Requirements
- R1: Transfer control (offset 0x04) stores the mode in bits 27:24, the write count minus one in bits 20:12 and the read count minus one in bits 8:0. It reads back exactly those fields, with all other bits zero. The format register (0x00) reads a word length minus one of 7 in bits 12:8.
- R2: A write of any value to the command register (0x08) while idle starts a transfer. Status bit 0 (busy) stays 1 until the transfer ends. cs_n is low only during data phases. A command write while busy is ignored.
- R3: SCLK idles low. MOSI changes only while SCLK is low. MISO is sampled on each rising SCLK edge. Every byte is shifted most significant bit first.
- R4: Mode 1 sends write-count bytes taken from the transmit FIFO. Received bits are discarded, and the receive FIFO stays empty.
- R5: Mode 2 clocks in read-count bytes, each pushed into the receive FIFO. MOSI is held low, and the transmit FIFO is not popped.
- R6: Mode 0 exchanges write-count bytes. Each byte sent comes from the transmit FIFO, and each byte received is pushed into the receive FIFO.
- R7: Mode 3 first sends write-count bytes and then clocks in read-count bytes, with MOSI low. cs_n stays low without a break across both phases.
- R8: Mode 7, and any code other than 0 to 3, produces no SCLK edge and no chip-select assertion. Busy clears within two cycles.
- R9: If the transmit FIFO is empty when a write-phase byte is due, SCLK stays low and busy stays set until a byte is written.
- R10: Timing register bits 7:0 (div, reset value 3) set each SCLK half period to div+1 system clocks. div = 0xFF selects the fastest rate, one clock per half period.
- R11: Both FIFOs hold 16 bytes. A data write to a full transmit FIFO is dropped, and a data read from an empty receive FIFO returns 0. Status reports the receive count in bits 12:8, receive-empty in bit 14, the transmit count in bits 20:16, transmit-empty in bit 22 and transmit-full in bit 23.
- R12: Control (0x10) bit 0 aborts the engine (busy 0, cs_n high), bit 1 empties the receive FIFO and bit 2 empties the transmit FIFO. Each bit reads 1 in the cycle after the write and 0 once its reset has been applied one cycle later.
- R13: Writing data (0x0C) pushes bits 7:0 into the transmit FIFO. Reading it pops the receive FIFO, in first-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops data on the clock edge) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The hardest situation to reach is the switch from the write phase to the read phase in mode 3, because the byte index seen by the peripheral must continue without a chip-select break. The bench peripheral model counts chip-select falls and numbers the bytes it returns. A single count of one, together with a read-phase payload offset by the write count, proves the seam.

The write-phase stall is reached by starting a send with an empty transmit FIFO and only filling it many cycles later. An engine abort is fired mid-byte, after a fixed number of cycles chosen to fall inside the second received byte.

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);

  localparam int PW = $clog2(FIFO_DEPTH);
  localparam int CW = PW + 1;
  localparam int SW = ADDR_W - 2;

  localparam logic [SW-1:0] A_FMT   = SW'(0);
  localparam logic [SW-1:0] A_TCTRL = SW'(1);
  localparam logic [SW-1:0] A_CMD   = SW'(2);
  localparam logic [SW-1:0] A_DATA  = SW'(3);
  localparam logic [SW-1:0] A_CTRL  = SW'(4);
  localparam logic [SW-1:0] A_STAT  = SW'(5);
  localparam logic [SW-1:0] A_TIME  = SW'(6);

  typedef enum logic [1:0] {PH_IDLE, PH_WR, PH_RD, PH_END} phase_t;

  logic [SW-1:0] wsel;
  logic wr_tctrl, wr_cmd, wr_data, wr_ctrl, wr_time, rd_data;

  assign wsel     = bus_addr[ADDR_W-1:2];
  assign wr_tctrl = bus_wr && (wsel == A_TCTRL);
  assign wr_cmd   = bus_wr && (wsel == A_CMD);
  assign wr_data  = bus_wr && (wsel == A_DATA);
  assign wr_ctrl  = bus_wr && (wsel == A_CTRL);
  assign wr_time  = bus_wr && (wsel == A_TIME);
  assign rd_data  = bus_rd && (wsel == A_DATA);

  logic unused_bits;
  assign unused_bits = &{1'b0, bus_wdata[31:28], bus_wdata[23:21], bus_wdata[11:9], bus_addr[1:0]};

  logic [3:0] tc_mode;
  logic [8:0] tc_wcnt, tc_rcnt;
  logic [7:0] div_r;
  logic [2:0] rst_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_mode  <= 4'd0;
      tc_wcnt  <= 9'd0;
      tc_rcnt  <= 9'd0;
      div_r    <= 8'd3;
      rst_pend <= 3'b000;
    end else begin
      if (wr_tctrl) begin
        tc_mode <= bus_wdata[27:24];
        tc_wcnt <= bus_wdata[20:12];
        tc_rcnt <= bus_wdata[8:0];
      end
      if (wr_time) div_r <= bus_wdata[7:0];
      rst_pend <= wr_ctrl ? bus_wdata[2:0] : 3'b000;
    end
  end

  // engine state
  phase_t     phase;
  logic [3:0] cur_mode;
  logic [8:0] cur_rcnt, left;
  logic       active, sclk_r;
  logic [7:0] hcnt, sh_tx, sh_rx, lim;
  logic [2:0] bitn;
  logic       tick, byte_end, eng_pop, eng_push, busy;

  // transmit FIFO
  logic [7:0]    tx_mem [FIFO_DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_full, tx_empty, tx_push;
  logic [7:0]    tx_head;

  assign tx_full  = tx_cnt == CW'(FIFO_DEPTH);
  assign tx_empty = tx_cnt == '0;
  assign tx_push  = wr_data && !tx_full && !rst_pend[2];
  assign tx_head  = tx_mem[tx_rp];

  always_ff @(posedge clk) if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (rst_pend[2]) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + PW'(1);
      if (eng_pop) tx_rp <= tx_rp + PW'(1);
      case ({tx_push, eng_pop})
        2'b10:   tx_cnt <= tx_cnt + CW'(1);
        2'b01:   tx_cnt <= tx_cnt - CW'(1);
        default: tx_cnt <= tx_cnt;
      endcase
    end
  end

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(FIFO_DEPTH)); // R11

  // receive FIFO
  logic [7:0]    rx_mem [FIFO_DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic          rx_full, rx_empty, rx_push, rx_pop;

  assign rx_full  = rx_cnt == CW'(FIFO_DEPTH);
  assign rx_empty = rx_cnt == '0;
  assign rx_push  = eng_push && !rx_full && !rst_pend[1];
  assign rx_pop   = rd_data && !rx_empty && !rst_pend[1];

  always_ff @(posedge clk) if (rx_push) rx_mem[rx_wp] <= sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rst_pend[1]) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + PW'(1);
      if (rx_pop)  rx_rp <= rx_rp + PW'(1);
      case ({rx_push, rx_pop})
        2'b10:   rx_cnt <= rx_cnt + CW'(1);
        2'b01:   rx_cnt <= rx_cnt - CW'(1);
        default: rx_cnt <= rx_cnt;
      endcase
    end
  end

  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= CW'(FIFO_DEPTH)); // R11

  // phase sequencer
  assign lim      = (div_r == 8'hFF) ? 8'd0 : div_r;
  assign tick     = active && (hcnt == lim);
  assign byte_end = tick && sclk_r && (bitn == 3'd7);
  assign eng_pop  = (phase == PH_WR) && !active && !tx_empty && !rst_pend[2] && !rst_pend[0];
  assign eng_push = byte_end && !rst_pend[0] &&
                    ((phase == PH_RD) || ((phase == PH_WR) && (cur_mode == 4'd0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; cur_mode <= 4'd0; cur_rcnt <= 9'd0; left <= 9'd0;
      active <= 1'b0; sclk_r <= 1'b0; hcnt <= 8'd0; bitn <= 3'd0;
      sh_tx <= 8'd0; sh_rx <= 8'd0;
    end else if (rst_pend[0]) begin
      phase <= PH_IDLE; active <= 1'b0; sclk_r <= 1'b0; hcnt <= 8'd0; bitn <= 3'd0;
      sh_tx <= 8'd0;
    end else begin
      case (phase)
        PH_IDLE: if (wr_cmd) begin
          cur_mode <= tc_mode;
          cur_rcnt <= tc_rcnt;
          case (tc_mode)
            4'd0, 4'd1, 4'd3: begin phase <= PH_WR; left <= tc_wcnt; end
            4'd2:             begin phase <= PH_RD; left <= tc_rcnt; end
            default:          phase <= PH_END;
          endcase
        end
        PH_WR, PH_RD: begin
          if (!active) begin
            if (phase == PH_RD || eng_pop) begin
              active <= 1'b1;
              hcnt   <= 8'd0;
              bitn   <= 3'd0;
              sh_tx  <= (phase == PH_RD) ? 8'd0 : tx_head;
            end
          end else if (tick) begin
            hcnt <= 8'd0;
            if (!sclk_r) begin
              sclk_r <= 1'b1;
              sh_rx  <= {sh_rx[6:0], miso};
            end else begin
              sclk_r <= 1'b0;
              if (bitn == 3'd7) begin
                active <= 1'b0;
                if (left == 9'd0) begin
                  if (phase == PH_WR && cur_mode == 4'd3) begin
                    phase <= PH_RD;
                    left  <= cur_rcnt;
                  end else begin
                    phase <= PH_END;
                  end
                end else begin
                  left <= left - 9'd1;
                end
              end else begin
                bitn  <= bitn + 3'd1;
                sh_tx <= {sh_tx[6:0], 1'b0};
              end
            end
          end else begin
            hcnt <= hcnt + 8'd1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy = phase != PH_IDLE;
  assign sclk = sclk_r;
  assign mosi = active && sh_tx[7];
  assign cs_n = !((phase == PH_WR) || (phase == PH_RD));

  AST_SCLK_DESEL: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R3
  AST_MOSI_LOW:   assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_RD) |-> !mosi); // R5
  AST_STALL_LOW:  assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_WR && !active) |-> !sclk); // R9
  AST_TXF_CLR:    assert property (@(posedge clk) disable iff (!rst_n) rst_pend[2] |=> tx_empty); // R12
  AST_RXF_CLR:    assert property (@(posedge clk) disable iff (!rst_n) rst_pend[1] |=> rx_empty); // R12
  AST_ENG_ABORT:  assert property (@(posedge clk) disable iff (!rst_n) rst_pend[0] |=> (!busy && cs_n)); // R12
  AST_CMD_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) (busy && wr_cmd && phase != PH_END) |=> busy); // R2

  always_comb begin
    case (wsel)
      A_FMT:   bus_rdata = {19'd0, 5'd7, 8'd0};
      A_TCTRL: bus_rdata = {4'd0, tc_mode, 3'd0, tc_wcnt, 3'd0, tc_rcnt};
      A_DATA:  bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_mem[rx_rp]};
      A_CTRL:  bus_rdata = {29'd0, rst_pend};
      A_STAT:  bus_rdata = {8'd0, tx_full, tx_empty, 1'b0, 5'(tx_cnt),
                            1'b0, rx_empty, 1'b0, 5'(rx_cnt), 7'd0, busy};
      A_TIME:  bus_rdata = {24'd0, div_r};
      default: bus_rdata = 32'd0;
    endcase
  end

endmodule

// File: tb/spi_xfer_master_bench.sv
`timescale 1ns/1ps
module spi_xfer_master_bench;

  localparam logic [7:0] O_FMT = 8'h00, O_TC = 8'h04, O_CMD = 8'h08, O_DATA = 8'h0C,
                         O_CTRL = 8'h10, O_STAT = 8'h14, O_TIME = 8'h18;

  // {mode, write bytes, read bytes, tx base, peripheral base, div}
  localparam logic [43:0] VEC [6] = '{
    {4'd1, 8'd3,  8'd0,  8'h3C, 8'h00, 8'd0},
    {4'd2, 8'd0,  8'd4,  8'h00, 8'h51, 8'd1},
    {4'd0, 8'd5,  8'd0,  8'h96, 8'hC3, 8'hFF},
    {4'd3, 8'd2,  8'd3,  8'h9F, 8'h20, 8'd2},
    {4'd1, 8'd16, 8'd0,  8'h10, 8'h00, 8'hFF},
    {4'd2, 8'd0,  8'd16, 8'h00, 8'h70, 8'hFF}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  b_addr = 8'h00;
  logic        b_wr = 1'b0, b_rd = 1'b0;
  logic [31:0] b_wdata = 32'd0;
  logic [31:0] b_rdata;
  logic        sclk, mosi, cs_n;
  logic        miso = 1'b0;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  spi_xfer_master u_spi_xfer_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  // peripheral model: returns slv_base + byte index, logs what arrives on MOSI
  logic [7:0] mlog [64];
  logic [7:0] slv_base = 8'h00, sshift = 8'h00, tmp;
  int sidx = 0, sbit = 0, rises = 0, cs_falls = 0, cyc = 0, rise_prev = 0, rise_last = 0;

  always @(posedge clk) cyc++;

  always @(negedge cs_n) begin
    cs_falls++;
    sidx = 0; sbit = 0;
    miso = slv_base[7];
  end

  always @(posedge sclk) begin
    rises++;
    rise_prev = rise_last;
    rise_last = cyc;
    if (!cs_n) begin
      sshift = {sshift[6:0], mosi};
      sbit++;
      if (sbit == 8) begin
        if (sidx < 64) mlog[sidx] = sshift;
        sidx++;
        sbit = 0;
      end
    end
  end

  always @(negedge sclk) if (!cs_n) begin
    tmp  = slv_base + 8'(sidx);
    miso = tmp[7-sbit];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    b_addr = a; b_wdata = d; b_wr = 1'b1;
    @(negedge clk);
    b_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    b_addr = a; b_rd = 1'b1;
    #1 d = b_rdata;
    @(negedge clk);
    b_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n;
    n = 0;
    s = 32'd1;
    while (s[0] && n < 20000) begin
      rd_reg(O_STAT, s);
      n++;
    end
    if (s[0]) check("R2 busy never cleared", s, 32'd0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #3800000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [3:0]  mode;
    logic [7:0]  nw, nr, txb, slb, dv;
    int          nrx;
    string       tg;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd_reg(O_STAT, r);  check("R11 reset status", r, 32'h0040_4000);
    rd_reg(O_TIME, r);  check("R10 reset div", r, 32'd3);
    check("R2 reset cs_n/sclk", {30'd0, cs_n, sclk}, 32'd2);
    rd_reg(O_FMT, r);   check("R1 format length", r, 32'h0000_0700);

    // R1 field readback
    wr_reg(O_TC, 32'hFFFF_FFFF);
    rd_reg(O_TC, r);    check("R1 tctrl readback", r, 32'h0F1F_F1FF);

    // vector table
    for (int v = 0; v < 6; v++) begin
      {mode, nw, nr, txb, slb, dv} = VEC[v];
      tg = (mode == 4'd1) ? "R4" : (mode == 4'd2) ? "R5" : (mode == 4'd0) ? "R6" : "R7";
      slv_base = slb;
      wr_reg(O_TIME, {24'd0, dv});
      for (int i = 0; i < int'(nw); i++) wr_reg(O_DATA, {24'd0, txb + 8'(i)});
      cs_falls = 0;
      wr_reg(O_TC, {4'd0, mode, 3'd0, (nw == 0) ? 9'd0 : 9'(nw) - 9'd1,
                    3'd0, (nr == 0) ? 9'd0 : 9'(nr) - 9'd1});
      wr_reg(O_CMD, 32'd1);
      wait_idle();
      check({tg, " bytes clocked"}, 32'(sidx), 32'(nw) + 32'(nr));
      check({tg, " single cs assertion"}, 32'(cs_falls), 32'd1);
      for (int i = 0; i < int'(nw); i++)
        check({tg, "/R3 mosi byte"}, {24'd0, mlog[i]}, {24'd0, txb + 8'(i)});
      for (int j = 0; j < int'(nr); j++)
        check({tg, " mosi low while reading"}, {24'd0, mlog[int'(nw) + j]}, 32'd0);
      nrx = (mode == 4'd1) ? 0 : (mode == 4'd0) ? int'(nw) : int'(nr);
      rd_reg(O_STAT, r);
      check({tg, " status after transfer"}, r,
            {8'd0, 2'b01, 6'd0, (nrx == 0) ? 2'b01 : 2'b00, 1'b0, 5'(nrx), 8'd0});
      for (int j = 0; j < nrx; j++) begin
        rd_reg(O_DATA, r);
        check({tg, "/R13/R3 received byte"}, r,
              {24'd0, slb + 8'((mode == 4'd3) ? int'(nw) + j : j)});
      end
    end

    // R11 full FIFO drops writes
    for (int i = 0; i < 17; i++) wr_reg(O_DATA, 32'h40 + 32'(i));
    rd_reg(O_STAT, r);  check("R11 tx full status", r, 32'h0090_4000);

    // R12 self-clearing tx reset: write then read on consecutive cycles
    @(negedge clk);
    b_addr = O_CTRL; b_wdata = 32'd4; b_wr = 1'b1;
    @(negedge clk);
    b_wr = 1'b0; b_rd = 1'b1;
    #1 r = b_rdata;     check("R12 ctrl bit pending", r, 32'd4);
    @(negedge clk);
    #1 r = b_rdata;     check("R12 ctrl bit cleared", r, 32'd0);
    b_rd = 1'b0;
    rd_reg(O_STAT, r);  check("R12 tx emptied", r, 32'h0040_4000);

    // R11 empty read returns zero
    rd_reg(O_DATA, r);  check("R11 empty read", r, 32'd0);

    // R9 stall on empty tx FIFO
    slv_base = 8'h00;
    wr_reg(O_TIME, 32'd0);
    wr_reg(O_TC, 32'h0100_1000);
    rises = 0; cs_falls = 0;
    wr_reg(O_CMD, 32'd1);
    repeat (40) @(negedge clk);
    check("R9 no sclk while stalled", 32'(rises), 32'd0);
    rd_reg(O_STAT, r);  check("R9 busy while stalled", {31'd0, r[0]}, 32'd1);
    check("R9 cs held low", {31'd0, cs_n}, 32'd0);
    wr_reg(O_DATA, 32'hE1);
    wr_reg(O_DATA, 32'h1E);
    wait_idle();
    check("R9 first byte after stall", {24'd0, mlog[0]}, 32'hE1);
    check("R9 second byte after stall", {24'd0, mlog[1]}, 32'h1E);

    // R2 command while busy is ignored
    slv_base = 8'h33;
    wr_reg(O_TIME, 32'd3);
    wr_reg(O_TC, 32'h0200_0001);
    cs_falls = 0;
    wr_reg(O_CMD, 32'd1);
    repeat (10) @(negedge clk);
    rd_reg(O_STAT, r);  check("R2 busy mid transfer", {31'd0, r[0]}, 32'd1);
    wr_reg(O_CMD, 32'd1);
    wait_idle();
    check("R2 extra command ignored bytes", 32'(sidx), 32'd2);
    check("R2 extra command ignored cs", 32'(cs_falls), 32'd1);
    rd_reg(O_DATA, r);  check("R2 rx byte 0", r, 32'h33);
    rd_reg(O_DATA, r);  check("R2 rx byte 1", r, 32'h34);

    // R10 divider
    wr_reg(O_TIME, 32'd4);
    wr_reg(O_TC, 32'h0200_0000);
    wr_reg(O_CMD, 32'd1);
    wait_idle();
    check("R10 period div=4", 32'(rise_last - rise_prev), 32'd10);
    rd_reg(O_DATA, r);
    wr_reg(O_TIME, 32'hFF);
    wr_reg(O_CMD, 32'd1);
    wait_idle();
    check("R10 period div=FF", 32'(rise_last - rise_prev), 32'd2);
    rd_reg(O_DATA, r);

    // R8 no-data codes
    for (int k = 0; k < 2; k++) begin
      rises = 0; cs_falls = 0;
      wr_reg(O_TC, (k == 0) ? 32'h0700_0000 : 32'h0B00_0000);
      wr_reg(O_CMD, 32'd1);
      repeat (2) @(negedge clk);
      rd_reg(O_STAT, r);  check("R8 busy cleared", {31'd0, r[0]}, 32'd0);
      check("R8 no sclk", 32'(rises), 32'd0);
      check("R8 no cs", 32'(cs_falls), 32'd0);
    end

    // R12 engine abort and rx reset
    slv_base = 8'h80;
    wr_reg(O_TIME, 32'd3);
    wr_reg(O_TC, 32'h0200_0003);
    wr_reg(O_CMD, 32'd1);
    repeat (100) @(negedge clk);
    wr_reg(O_CTRL, 32'd1);
    rd_reg(O_STAT, r);
    check("R12 abort busy", {31'd0, r[0]}, 32'd0);
    check("R12 abort rx count", {27'd0, r[12:8]}, 32'd1);
    check("R12 abort cs_n/sclk", {30'd0, cs_n, sclk}, 32'd2);
    wr_reg(O_CTRL, 32'd2);
    rd_reg(O_STAT, r);  check("R12 rx emptied", r, 32'h0040_4000);

    finish_run();
  end

endmodule